// File: doc/BRIEF.md
# Initial Bad Block Scanner

This engine runs once after power-on, on the controller side of a NAND flash interface. It walks every erase block, starting at block 0 and counting upward to the last block. For each block it reads the factory bad-block marker, which is spare byte 5 (page column 517), in the first two pages of the block. If either byte differs from the erased value FFh, the block is recorded as bad. Reads go through a request/response port to a separate NAND sequencer, which handles pin-level cycles and the spare-area pointer command. The scanner only ever asks for single-byte reads, so the markers are never altered.

The block writes one entry per erase block to an external invalid-block bitmap. It keeps a running count of bad blocks. When the last block has been written, it raises `done`. It also raises `warn` when the count exceeds a limit, since a healthy part has at most 70 bad blocks out of 4096.

The control is a five-state machine:
- `ST_IDLE`: reset state; waits for `start`.
- `ST_ISSUE`: presents a read request; waits for `req_ready`.
- `ST_WAIT`: waits for `rsp_valid`.
- `ST_POST`: writes the bitmap entry for the current block.
- `ST_DONE`: holds the results.

Transitions:
- idle/done→issue when `start` is seen.
- issue→wait when the request is accepted.
- wait→issue when page 0 returns FFh (the machine moves on to page 1).
- wait→post when a marker is bad, or when page 1 returns FFh.
- post→issue for the next block.
- post→done after the last block.

Top module: `bad_block_scanner`

## Requirements
- R1: After reset the outputs are `req_valid`=0, `map_we`=0, `done`=0, `warn`=0 and `bad_count`=0.
- R2: A scan writes the bitmap exactly once per block. Writes go in ascending block order from 0 to BLOCKS-1, with `map_addr` equal to the block number.
- R3: Every request has `req_spare_ofs`=5. Its `req_row` is block*PAGES+page, where page is 0 or 1 (the low log2(PAGES) bits of the row carry the page). Page 0 of a block is requested before page 1.
- R4: `map_bad`=1 when the marker byte of page 0 or page 1 is not FFh. Otherwise `map_bad`=0.
- R5: When the page 0 marker is not FFh, page 1 of that block is not requested.
- R6: Only one read is outstanding at a time. While `req_valid` is high and `req_ready` is low, the request and its row stay unchanged.
- R7: `bad_count` equals the number of blocks written with `map_bad`=1. `done` rises after the last bitmap write and stays high until a new `start`.
- R8: `warn` is 1 only while `done` is high and `bad_count` is strictly greater than WARN_LIMIT.
- R9: `start` is ignored while a scan is running. A `start` while idle or done begins a new scan: `done` drops and `bad_count` clears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a scan |
| req_valid | output | 1 | read request present |
| req_ready | input | 1 | sequencer accepts request |
| req_row | output | ROW_W | row (page) address of the read |
| req_spare_ofs | output | 4 | byte offset in the spare area |
| rsp_valid | input | 1 | read data returned |
| rsp_data | input | 8 | marker byte |
| map_we | output | 1 | bitmap write strobe |
| map_addr | output | BLK_W | block number being written |
| map_bad | output | 1 | 1 = block invalid |
| bad_count | output | CNT_W | bad blocks found |
| done | output | 1 | scan complete |
| warn | output | 1 | bad count above limit |

## Verification
The bench plants markers in three places:
- on page 0 only, which a design that always reads both pages would expose through an extra page-1 request;
- on page 1 only, which a design that reads a single page would mark good;
- on the last block, which an off-by-one end test would skip or overrun.

The bad count is placed exactly at the limit and one above it, to catch a non-strict comparison. The sequencer model stalls `req_ready` and delays responses, so a design that changes the row before acceptance, or issues a new request before data returns, is detected. A `start` pulse in the middle of a scan checks that the count is neither cleared nor restarted.

// File: rtl/bbscan_pkg.sv
package bbscan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_POST,
        ST_DONE
    } scan_state_t;

    localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/bbscan_rowgen.sv
module bbscan_rowgen #(
    parameter int BLK_W = 12,
    parameter int PG_W  = 5,
    localparam int ROW_W = BLK_W + PG_W
) (
    input  logic [BLK_W-1:0] blk,
    input  logic             page_sel,
    output logic [ROW_W-1:0] row
);
    always_comb begin
        row = (ROW_W'(blk) << PG_W) | ROW_W'(page_sel);
    end
endmodule

// File: rtl/bbscan_tally.sv
module bbscan_tally #(
    parameter int CNT_W = 13,
    parameter int LIMIT = 70
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] count,
    output logic             over
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (bump) begin
            count <= count + 1'b1;
        end
    end

    always_comb begin
        over = int'(count) > LIMIT;
    end
endmodule

// File: rtl/bad_block_scanner.sv
module bad_block_scanner
    import bbscan_pkg::*;
#(
    parameter int BLOCKS     = 4096,
    parameter int PAGES      = 32,
    parameter int SPARE_OFS  = 5,
    parameter int WARN_LIMIT = 70,
    localparam int BLK_W = $clog2(BLOCKS),
    localparam int PG_W  = $clog2(PAGES),
    localparam int ROW_W = BLK_W + PG_W,
    localparam int CNT_W = $clog2(BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [ROW_W-1:0] req_row,
    output logic [3:0]       req_spare_ofs,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_data,
    output logic             map_we,
    output logic [BLK_W-1:0] map_addr,
    output logic             map_bad,
    output logic [CNT_W-1:0] bad_count,
    output logic             done,
    output logic             warn
);
    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(BLOCKS - 1);

    scan_state_t      state_q, state_d;
    logic [BLK_W-1:0] blk_q;
    logic             page_q;
    logic             bad_q;
    logic             launch;
    logic             over_lim;

    // a start is only honoured when no scan is running
    always_comb begin
        launch = start && (state_q == ST_IDLE || state_q == ST_DONE);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (launch) state_d = ST_ISSUE;
            ST_ISSUE: if (req_ready) state_d = ST_WAIT;
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_data != ERASED_BYTE || page_q) state_d = ST_POST;
                    else                                   state_d = ST_ISSUE;
                end
            end
            ST_POST:  state_d = (blk_q == LAST_BLK) ? ST_DONE : ST_ISSUE;
            ST_DONE:  if (launch) state_d = ST_ISSUE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blk_q   <= '0;
            page_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (launch) begin
                blk_q  <= '0;
                page_q <= 1'b0;
                bad_q  <= 1'b0;
            end else if (state_q == ST_WAIT && rsp_valid) begin
                if (rsp_data != ERASED_BYTE) begin
                    bad_q <= 1'b1;
                end else if (!page_q) begin
                    page_q <= 1'b1;
                end else begin
                    bad_q <= 1'b0;
                end
            end else if (state_q == ST_POST && blk_q != LAST_BLK) begin
                blk_q  <= blk_q + 1'b1;
                page_q <= 1'b0;
                bad_q  <= 1'b0;
            end
        end
    end

    bbscan_rowgen #(.BLK_W(BLK_W), .PG_W(PG_W)) u_rowgen (
        .blk      (blk_q),
        .page_sel (page_q),
        .row      (req_row)
    );

    bbscan_tally #(.CNT_W(CNT_W), .LIMIT(WARN_LIMIT)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .bump  (state_q == ST_POST && bad_q),
        .count (bad_count),
        .over  (over_lim)
    );

    always_comb begin
        req_valid     = (state_q == ST_ISSUE);
        req_spare_ofs = 4'(SPARE_OFS);
        map_we        = (state_q == ST_POST);
        map_addr      = blk_q;
        map_bad       = bad_q;
        done          = (state_q == ST_DONE);
        warn          = (state_q == ST_DONE) && over_lim;
    end
endmodule

// File: rtl/bbscan_checker.sv
module bbscan_checker #(
    parameter int BLOCKS     = 4096,
    parameter int PAGES      = 32,
    parameter int WARN_LIMIT = 70,
    localparam int BLK_W = $clog2(BLOCKS),
    localparam int PG_W  = $clog2(PAGES),
    localparam int ROW_W = BLK_W + PG_W,
    localparam int CNT_W = $clog2(BLOCKS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             req_valid,
    input logic             req_ready,
    input logic [ROW_W-1:0] req_row,
    input logic             map_we,
    input logic             map_bad,
    input logic [CNT_W-1:0] bad_count,
    input logic             done,
    input logic             warn
);
    p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_row));

    p_page_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_row[PG_W-1:0] <= PG_W'(1)));

    p_count_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
        map_we && map_bad |=> bad_count == $past(bad_count) + 1'b1);

    p_count_good_r7: assert property (@(posedge clk) disable iff (!rst_n)
        map_we && !map_bad |=> $stable(bad_count));

    p_quiet_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_valid && !map_we);

    p_warn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> done && (int'(bad_count) > WARN_LIMIT));

    p_done_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);
endmodule

bind bad_block_scanner bbscan_checker #(
    .BLOCKS(BLOCKS), .PAGES(PAGES), .WARN_LIMIT(WARN_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
    .map_we(map_we), .map_bad(map_bad), .bad_count(bad_count),
    .done(done), .warn(warn)
);

// File: tb/bad_block_scanner_test.sv
module bad_block_scanner_test;
    localparam int NB    = 64;
    localparam int LIM   = 5;
    localparam int ROW_W = 11;
    localparam int BLK_W = 6;
    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             req_valid, req_ready;
    logic [ROW_W-1:0] req_row;
    logic [3:0]       req_spare_ofs;
    logic             rsp_valid;
    logic [7:0]       rsp_data;
    logic             map_we, map_bad, done, warn;
    logic [BLK_W-1:0] map_addr;
    logic [CNT_W-1:0] bad_count;

    int errors = 0;
    int checks = 0;

    logic [7:0] mk0 [NB];
    logic [7:0] mk1 [NB];
    int rd0 [NB];
    int rd1 [NB];
    int map_val [NB];
    int wr_cnt, next_addr, lat_cfg, stall_cfg;
    bit order_bad, ofs_bad, stab_bad;

    always #5 clk = ~clk;

    bad_block_scanner #(.BLOCKS(NB), .PAGES(32), .SPARE_OFS(5), .WARN_LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_valid(req_valid), .req_ready(req_ready), .req_row(req_row),
        .req_spare_ofs(req_spare_ofs), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .map_we(map_we), .map_addr(map_addr), .map_bad(map_bad),
        .bad_count(bad_count), .done(done), .warn(warn)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // bitmap monitor
    initial begin
        forever begin
            @(negedge clk);
            if (map_we) begin
                if (int'(map_addr) != next_addr) order_bad = 1'b1;
                map_val[map_addr] = int'(map_bad);
                wr_cnt++;
                next_addr++;
            end
        end
    end

    // sequencer model
    initial begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = 8'h00;
        forever begin
            @(negedge clk);
            if (req_valid) begin
                automatic logic [ROW_W-1:0] row = req_row;
                automatic int b = int'(row) / 32;
                automatic int p = int'(row) % 32;
                repeat (stall_cfg) begin
                    @(negedge clk);
                    if (!req_valid || req_row != row) stab_bad = 1'b1;
                end
                if (req_spare_ofs != 4'd5) ofs_bad = 1'b1;
                if (p == 0) rd0[b]++;
                else if (p == 1) begin
                    rd1[b]++;
                    if (rd0[b] != 1) ofs_bad = 1'b1;
                end else ofs_bad = 1'b1;
                req_ready = 1'b1;
                @(negedge clk);
                req_ready = 1'b0;
                if (req_valid) stab_bad = 1'b1;
                repeat (lat_cfg) begin
                    @(negedge clk);
                    if (req_valid) stab_bad = 1'b1;
                end
                rsp_valid = 1'b1;
                rsp_data  = (p == 0) ? mk0[b] : mk1[b];
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic fill_good();
        for (int i = 0; i < NB; i++) begin
            mk0[i] = 8'hFF;
            mk1[i] = 8'hFF;
        end
    endtask

    task automatic run_scan(input string tag, input int lat, input int stall, input bit poke);
        int exp_cnt = 0;
        int wait_cyc = 0;
        bit map_ok = 1'b1, rd_ok = 1'b1, skip_ok = 1'b1;
        for (int i = 0; i < NB; i++) begin
            rd0[i] = 0; rd1[i] = 0; map_val[i] = -1;
        end
        wr_cnt = 0; next_addr = 0;
        order_bad = 1'b0; ofs_bad = 1'b0; stab_bad = 1'b0;
        lat_cfg = lat; stall_cfg = stall;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(!done && bad_count == 0, "R9", {tag, " restart clears"}, int'(bad_count), 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && wait_cyc < 20000) begin
            @(negedge clk);
            wait_cyc++;
        end
        for (int i = 0; i < NB; i++) begin
            automatic int eb = (mk0[i] != 8'hFF || mk1[i] != 8'hFF) ? 1 : 0;
            exp_cnt += eb;
            if (map_val[i] != eb) map_ok = 1'b0;
            if (rd0[i] != 1) rd_ok = 1'b0;
            if (rd1[i] != ((mk0[i] == 8'hFF) ? 1 : 0)) skip_ok = 1'b0;
        end
        chk(done, "R7", {tag, " done"}, int'(done), 1);
        chk(wr_cnt == NB && !order_bad, "R2", {tag, " write order/count"}, wr_cnt, NB);
        chk(map_ok, "R4", {tag, " bitmap contents"}, int'(map_ok), 1);
        chk(rd_ok && !ofs_bad, "R3", {tag, " request rows/offset"}, int'(rd_ok && !ofs_bad), 1);
        chk(skip_ok, "R5", {tag, " page1 skip"}, int'(skip_ok), 1);
        chk(!stab_bad, "R6", {tag, " request hold"}, int'(stab_bad), 0);
        chk(int'(bad_count) == exp_cnt, "R7", {tag, " bad_count"}, int'(bad_count), exp_cnt);
        chk(warn == (exp_cnt > LIM), "R8", {tag, " warn"}, int'(warn), int'(exp_cnt > LIM));
        repeat (3) @(negedge clk);
        chk(done && wr_cnt == NB, "R7", {tag, " done holds"}, wr_cnt, NB);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!req_valid && !map_we && !done && !warn && bad_count == 0, "R1",
            "reset outputs", int'({req_valid, map_we, done, warn}), 0);
    endtask

    task automatic t_all_good();
        fill_good();
        run_scan("all-good", 0, 0, 1'b0);
    endtask

    task automatic t_mixed();
        fill_good();
        mk0[3]  = 8'h00;
        mk1[7]  = 8'hFE;
        mk0[9]  = 8'h7F;
        mk1[9]  = 8'h7F;
        mk1[63] = 8'hEF;
        run_scan("mixed", 2, 1, 1'b0);
    endtask

    task automatic t_warn_edge();
        fill_good();
        for (int i = 1; i <= LIM; i++) mk0[i * 10] = 8'h0F;
        run_scan("at-limit", 1, 0, 1'b0);
        mk1[NB - 1] = 8'h00;
        run_scan("over-limit", 0, 2, 1'b0);
    endtask

    task automatic t_midscan_start();
        fill_good();
        mk0[2]  = 8'hF7;
        mk1[30] = 8'h80;
        run_scan("midscan-start", 1, 1, 1'b1);
    endtask

    initial begin
        lat_cfg = 0; stall_cfg = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_all_good();
        t_mixed();
        t_warn_edge();
        t_midscan_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule